// File: doc/BRIEF.md
# Multiplexed Synchronous Burst Bus Slave

This block sits on a host's external bus. That bus shares sixteen wires between address and data and moves each 32-bit register word as two half-word beats, timed by a burst clock that the host supplies. Every accepted access becomes exactly one 32-bit read or write on a simple internal register bus (index, write strobe, write data, read strobe, read data). The burst clock is the block's only clock, so the block contains no clock-domain crossing.

An access starts when chip select and the address-valid strobe are both low at a burst-clock rising edge. The upper twelve address bits must equal the block's own select code (default 0x321); otherwise the access is ignored. Address bits 3:2 pick one of four register words, and bits 1:0 are zero. A write (write enable low during the address phase) brings the low beat and then the high beat. A read holds the host back with an active-low wait for one cycle while the internal read takes place, then returns the low half-word followed by the high half-word. The data bus is split into an input, an output and an output enable, which a pad ring combines into the bidirectional pin.

Top module: `mbs_top`

## Requirements
- R1: While reset is high and in the first cycle after it, wait_n is 1 and ad_oe, reg_wr and reg_rd are 0.
- R2: The address is taken from ad_in at a rising edge where cs_n and adv_n are both low in the idle state. It is a hit only if ad_in[15:4] equals 0x321, and ad_in[3:2] then appears on reg_idx from the next cycle on.
- R3: A hit with we_n low during the address phase is a write. The beat on ad_in at the first edge after the address edge forms reg_wdata[15:0], and the beat at the second edge forms reg_wdata[31:16].
- R4: For a write, reg_wr is high for exactly one cycle, the cycle right after the second beat edge, with reg_idx and reg_wdata valid. It fires at most once per chip-select period.
- R5: A hit with we_n high during the address phase is a read. reg_rd is high and wait_n is low for exactly the one cycle after the address edge, and reg_rdata is sampled at the end of that cycle.
- R6: In the cycle after wait_n returns high, ad_out carries read word bits 15:0. In the following cycle it carries bits 31:16. After that the bus is released.
- R7: ad_oe is 1 only while cs_n is low, oe_n is low and the read is in one of its two data cycles; at all other times it is 0.
- R8: A miss (select bits not 0x321) produces no wait, no bus drive, no reg_wr and no reg_rd, and leaves every register word unchanged.
- R9: cs_n high at any edge returns the block to idle. A write whose chip select rises before its second beat produces no reg_wr, and the next access needs a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock from the host |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ad_in | input | 16 | Shared address/data bus, incoming value |
| ad_out | output | 16 | Shared bus, outgoing read beat |
| ad_oe | output | 1 | Output enable for the shared bus driver |
| wait_n | output | 1 | Wait request to the host, active low |
| reg_idx | output | 2 | Internal register word index |
| reg_wr | output | 1 | Internal write strobe |
| reg_wdata | output | 32 | Internal write data |
| reg_rd | output | 1 | Internal read strobe |
| reg_rdata | input | 32 | Internal read data, sampled while reg_rd is high |

## Verification
The assertions check on every cycle that the driver is enabled only under chip select and output enable, that the write and read strobes and the wait pulse each last one cycle and never overlap, that a write strobe follows two cycles of held chip select, and that the read index matches the address seen at the address edge. Only the bench scenarios can show correct data: beats assembled into the right halves, the read word returned low half first, ignored misses leaving the register words untouched, and an aborted write producing no store. Random mixes of hits, misses, reads and writes are compared against a bench model of the four words.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int unsigned MBS_BEAT_W   = 16;
    localparam int unsigned MBS_IDX_W    = 2;
    localparam logic [11:0] MBS_BLOCK_ID = 12'h321;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_WR_PULSE,
        ST_RD_REQ,
        ST_RD_LO,
        ST_RD_HI,
        ST_HOLD
    } mbs_state_e;

    typedef struct packed {
        logic wait_n;
        logic reg_wr;
        logic reg_rd;
        logic data_phase;
    } mbs_ctrl_t;

    function automatic mbs_ctrl_t decode_state(input mbs_state_e s);
        mbs_ctrl_t c;
        c.wait_n     = (s != ST_RD_REQ);
        c.reg_wr     = (s == ST_WR_PULSE);
        c.reg_rd     = (s == ST_RD_REQ);
        c.data_phase = (s == ST_RD_LO) || (s == ST_RD_HI);
        return c;
    endfunction

endpackage

// File: rtl/mbs_addr_decode.sv
module mbs_addr_decode #(
    parameter int unsigned BEAT_W   = 16,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned SEL_W    = BEAT_W - IDX_W - 2,
    parameter logic [SEL_W-1:0] BLOCK_ID = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BEAT_W-1:0] ad_in,
    output logic              hit,
    output logic [IDX_W-1:0]  idx_q
);
    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned SEL_LSB = IDX_LSB + IDX_W;

    assign hit = (ad_in[BEAT_W-1:SEL_LSB] == BLOCK_ID);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (capture && hit) begin
            idx_q <= ad_in[SEL_LSB-1:IDX_LSB];
        end
    end
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
    import mbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       adv_n,
    input  logic       we_n,
    input  logic       hit,
    output logic       addr_cap,
    output mbs_state_e state
);
    mbs_state_e state_nx;

    assign addr_cap = (state == ST_IDLE) && !cs_n && !adv_n;

    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (addr_cap) begin
                        if (!hit)      state_nx = ST_HOLD;
                        else if (!we_n) state_nx = ST_WR_LO;
                        else            state_nx = ST_RD_REQ;
                    end
                end
                ST_WR_LO:    state_nx = ST_WR_HI;
                ST_WR_HI:    state_nx = ST_WR_PULSE;
                ST_WR_PULSE: state_nx = ST_HOLD;
                ST_RD_REQ:   state_nx = ST_RD_LO;
                ST_RD_LO:    state_nx = ST_RD_HI;
                ST_RD_HI:    state_nx = ST_HOLD;
                ST_HOLD:     state_nx = ST_HOLD;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/mbs_beat_path.sv
module mbs_beat_path
    import mbs_pkg::*;
#(
    parameter int unsigned BEAT_W = 16,
    parameter int unsigned NBEATS = 2,
    parameter int unsigned WORD_W = BEAT_W * NBEATS
) (
    input  logic              clk,
    input  logic              rst,
    input  mbs_state_e        state,
    input  logic [BEAT_W-1:0] ad_in,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic [WORD_W-1:0] reg_wdata,
    output logic [BEAT_W-1:0] ad_out
);
    localparam mbs_state_e WR_ST [NBEATS] = '{ST_WR_LO, ST_WR_HI};
    localparam mbs_state_e RD_ST [NBEATS] = '{ST_RD_LO, ST_RD_HI};

    logic [WORD_W-1:0] rbuf;
    logic [BEAT_W-1:0] lane_out [NBEATS];

    for (genvar g = 0; g < NBEATS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                reg_wdata[g*BEAT_W +: BEAT_W] <= '0;
            end else if (state == WR_ST[g]) begin
                reg_wdata[g*BEAT_W +: BEAT_W] <= ad_in;
            end
        end
        assign lane_out[g] = (state == RD_ST[g]) ? rbuf[g*BEAT_W +: BEAT_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)                     rbuf <= '0;
        else if (state == ST_RD_REQ) rbuf <= reg_rdata;
    end

    always_comb begin
        ad_out = '0;
        for (int i = 0; i < NBEATS; i++) ad_out = ad_out | lane_out[i];
    end
endmodule

// File: rtl/mbs_top.sv
module mbs_top
    import mbs_pkg::*;
#(
    parameter int unsigned BEAT_W = MBS_BEAT_W,
    parameter int unsigned IDX_W  = MBS_IDX_W,
    parameter logic [BEAT_W-IDX_W-3:0] BLOCK_ID = MBS_BLOCK_ID
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  adv_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [BEAT_W-1:0]     ad_in,
    output logic [BEAT_W-1:0]     ad_out,
    output logic                  ad_oe,
    output logic                  wait_n,
    output logic [IDX_W-1:0]      reg_idx,
    output logic                  reg_wr,
    output logic [2*BEAT_W-1:0]   reg_wdata,
    output logic                  reg_rd,
    input  logic [2*BEAT_W-1:0]   reg_rdata
);
    localparam int unsigned SEL_W = BEAT_W - IDX_W - 2;

    logic       hit;
    logic       addr_cap;
    mbs_state_e state;
    mbs_ctrl_t  ctl;

    mbs_addr_decode #(
        .BEAT_W(BEAT_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .BLOCK_ID(BLOCK_ID)
    ) u_dec (
        .clk(clk), .rst(rst), .capture(addr_cap), .ad_in(ad_in),
        .hit(hit), .idx_q(reg_idx)
    );

    mbs_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
        .hit(hit), .addr_cap(addr_cap), .state(state)
    );

    mbs_beat_path #(.BEAT_W(BEAT_W), .NBEATS(2)) u_path (
        .clk(clk), .rst(rst), .state(state), .ad_in(ad_in),
        .reg_rdata(reg_rdata), .reg_wdata(reg_wdata), .ad_out(ad_out)
    );

    assign ctl    = decode_state(state);
    assign wait_n = ctl.wait_n;
    assign reg_wr = ctl.reg_wr;
    assign reg_rd = ctl.reg_rd;
    assign ad_oe  = ctl.data_phase && !cs_n && !oe_n;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int unsigned BEAT_W = 16,
    parameter int unsigned IDX_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              oe_n,
    input logic [BEAT_W-1:0] ad_in,
    input logic              ad_oe,
    input logic              wait_n,
    input logic [IDX_W-1:0]  reg_idx,
    input logic              reg_wr,
    input logic              reg_rd
);
    AST_OE_GUARD:    assert property (@(posedge clk) disable iff (rst) ad_oe |-> (!cs_n && !oe_n)); // R7
    AST_WR_SINGLE:   assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr); // R4
    AST_RD_SINGLE:   assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd); // R5
    AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (rst) !wait_n |=> wait_n); // R5
    AST_EXCLUSIVE:   assert property (@(posedge clk) disable iff (rst) $onehot0({reg_wr, reg_rd, ad_oe})); // R7
    AST_WR_HELD_CS:  assert property (@(posedge clk) disable iff (rst)
                         reg_wr |-> ($past(!cs_n) && $past(!cs_n, 2))); // R9
    AST_RD_INDEX:    assert property (@(posedge clk) disable iff (rst)
                         reg_rd |-> (reg_idx == $past(ad_in[IDX_W+1:2]))); // R2
endmodule

bind mbs_top mbs_checker #(.BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_mbs_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .ad_in(ad_in),
    .ad_oe(ad_oe), .wait_n(wait_n), .reg_idx(reg_idx),
    .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/mbs_top_tb_top.sv
module mbs_top_tb_top;
    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe, wait_n, reg_wr, reg_rd;
    logic [1:0]  reg_idx;
    logic [31:0] reg_wdata, reg_rdata;

    logic [31:0] mem [4];
    logic [31:0] exp_mem [4];
    int unsigned wr_pulses = 0;
    int unsigned rd_pulses = 0;
    int unsigned n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbs_top dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .wait_n(wait_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_idx];

    always @(posedge clk) begin
        if (!rst && reg_wr) begin
            mem[reg_idx] <= reg_wdata;
            wr_pulses    <= wr_pulses + 1;
        end
        if (!rst && reg_rd) rd_pulses <= rd_pulses + 1;
    end

    function automatic logic [15:0] mk_addr(input logic [1:0] idx, input bit hit, input logic [11:0] other);
        logic [11:0] sel;
        sel = hit ? 12'h321 : ((other == 12'h321) ? 12'h320 : other);
        return {sel, idx, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [15:0] addr, input logic [31:0] data, input bit abort);
        bit hit;
        int unsigned w0;
        hit = (addr[15:4] == 12'h321);
        w0  = wr_pulses;
        @(negedge clk); cs_n = 0; adv_n = 0; we_n = 0; ad_in = addr;
        @(negedge clk); adv_n = 1; ad_in = data[15:0];
        chk(wait_n == 1'b1, "R8/R3 no wait on write", {31'd0, wait_n}, 32'd1);
        if (abort) begin
            cs_n = 1; we_n = 1;
            @(negedge clk); ad_in = data[31:16];
            @(negedge clk);
            @(negedge clk);
            chk(wr_pulses == w0, "R9 aborted write stores nothing", wr_pulses, w0);
            return;
        end
        @(negedge clk); ad_in = data[31:16];
        @(negedge clk);
        chk(reg_wr == hit, "R4 write strobe after second beat", {31'd0, reg_wr}, {31'd0, hit});
        if (hit) begin
            chk(reg_wdata == data, "R3 beats assembled low then high", reg_wdata, data);
            chk(reg_idx == addr[3:2], "R2 index from address bits 3:2", {30'd0, reg_idx}, {30'd0, addr[3:2]});
            exp_mem[addr[3:2]] = data;
        end
        chk(ad_oe == 1'b0, "R7 no drive during write", {31'd0, ad_oe}, 32'd0);
        @(negedge clk);
        chk(reg_wr == 1'b0, "R4 strobe lasts one cycle", {31'd0, reg_wr}, 32'd0);
        cs_n = 1; we_n = 1; ad_in = '0;
        @(negedge clk);
        chk(wr_pulses == w0 + (hit ? 1 : 0), "R4/R8 write strobe count", wr_pulses, w0 + (hit ? 1 : 0));
    endtask

    task automatic do_read(input logic [15:0] addr, input bit oe_high);
        bit hit;
        int unsigned r0;
        logic [31:0] e;
        hit = (addr[15:4] == 12'h321);
        r0  = rd_pulses;
        e   = exp_mem[addr[3:2]];
        @(negedge clk); cs_n = 0; adv_n = 0; we_n = 1; ad_in = addr;
        @(negedge clk); adv_n = 1; oe_n = oe_high; ad_in = '0;
        chk(wait_n == !hit, "R5/R8 wait low one cycle on hit read", {31'd0, wait_n}, {31'd0, !hit});
        chk(reg_rd == hit, "R5/R8 read strobe", {31'd0, reg_rd}, {31'd0, hit});
        chk(ad_oe == 1'b0, "R7 no drive while waiting", {31'd0, ad_oe}, 32'd0);
        for (int n = 0; n < 8 && wait_n == 1'b0; n++) @(negedge clk);
        chk(ad_oe == (hit && !oe_high), "R7/R8 drive in low beat", {31'd0, ad_oe}, {31'd0, hit && !oe_high});
        if (hit) chk(ad_out == e[15:0], "R6 low half first", {16'd0, ad_out}, {16'd0, e[15:0]});
        @(negedge clk);
        chk(ad_oe == (hit && !oe_high), "R7/R8 drive in high beat", {31'd0, ad_oe}, {31'd0, hit && !oe_high});
        if (hit) chk(ad_out == e[31:16], "R6 high half second", {16'd0, ad_out}, {16'd0, e[31:16]});
        @(negedge clk);
        chk(ad_oe == 1'b0, "R6 bus released after two beats", {31'd0, ad_oe}, 32'd0);
        cs_n = 1; oe_n = 1;
        @(negedge clk);
        chk(rd_pulses == r0 + (hit ? 1 : 0), "R5 one read strobe per access", rd_pulses, r0 + (hit ? 1 : 0));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 4; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        chk(wait_n == 1 && ad_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1 quiet in reset",
            {28'd0, wait_n, ad_oe, reg_wr, reg_rd}, 32'h8);
        rst = 0;
        @(negedge clk);
        chk(wait_n == 1 && ad_oe == 0 && reg_wr == 0 && reg_rd == 0, "R1 quiet after reset",
            {28'd0, wait_n, ad_oe, reg_wr, reg_rd}, 32'h8);

        // directed
        do_write(mk_addr(2'd0, 1, 0), 32'hAA55A5A5, 0);
        do_write(mk_addr(2'd1, 1, 0), 32'h11221212, 0);
        do_read (mk_addr(2'd0, 1, 0), 0);
        do_read (mk_addr(2'd1, 1, 0), 0);
        do_write(mk_addr(2'd1, 0, 12'h123), 32'hDEADBEEF, 0);   // R8 miss ignored
        do_read (mk_addr(2'd1, 1, 0), 0);
        do_read (mk_addr(2'd1, 0, 12'h321), 0);                 // R8 near miss
        do_write(mk_addr(2'd3, 1, 0), 32'h0BADF00D, 1);         // R9 abort
        do_read (mk_addr(2'd3, 1, 0), 0);
        do_read (mk_addr(2'd0, 1, 0), 1);                       // R7 oe held high
        do_write(mk_addr(2'd3, 1, 0), 32'hFFFF0000, 0);
        do_read (mk_addr(2'd3, 1, 0), 0);

        // constrained random
        for (int k = 0; k < 60; k++) begin
            logic [1:0]  idx;
            bit          hit, wr;
            logic [31:0] d;
            logic [11:0] o;
            idx = 2'($urandom_range(0, 3));
            hit = ($urandom_range(0, 3) != 0);
            wr  = $urandom_range(0, 1) == 1;
            d   = $urandom();
            o   = 12'($urandom());
            if (wr) do_write(mk_addr(idx, hit, o), d, 0);
            else    do_read (mk_addr(idx, hit, o), 0);
        end
        for (int i = 0; i < 4; i++) do_read(mk_addr(2'(i), 1, 0), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule